// File: doc/BRIEF.md
# Prefilled Timestamp Jitter FIFO

This block sits on one port of a clock-recovery path. Residual timestamp values come in with delay variation. The block stores them in a small circular buffer and hands them to a clock-recovery PLL whenever the PLL asks for one at its steady rate. While the buffer is still filling, read requests are ignored and the PLL is told to free-run. This lasts until a set number of entries (PREFILL, default 5 of DEPTH 8) have been stored. That leaves room for DEPTH-PREFILL late-arriving surplus values and PREFILL missing values before anything goes wrong.

If the buffer overflows or underflows, the block raises a sticky flag and discards its contents. It sends the PLL back into free-run and waits for a fresh prefill. Incoming values are gated off when the port does not use timestamps or is powered down. Each flag is cleared by a one-cycle clear strobe.

Top module: `ts_jitter_fifo`

## Requirements
- R1: A write is accepted only when `wr_valid`=1, `ts_enable`=1 and `power_down`=0. Accepted values are delivered in the order they were written, holding up to DEPTH (default 8) entries.
- R2: After reset or restart, `free_run` is 1 and `rd_req` has no effect (no `rd_valid`, no underflow). `free_run` falls at the clock edge that stores the PREFILL-th entry (default 5).
- R3: While `free_run`=0, an `rd_req` with at least one entry stored puts the oldest entry on `rd_data` and pulses `rd_valid` for one cycle, both in the cycle after the edge.
- R4: An accepted write while DEPTH entries are stored is an overflow, even with `rd_req` in the same cycle. The write is dropped, all contents are discarded, `free_run` returns to 1 and `ovf_flag` is 1 after that edge.
- R5: An `rd_req` while `free_run`=0 and no entry is stored is an underflow. A write in the same cycle is also discarded, `free_run` returns to 1, `unf_flag` is 1 after that edge, `rd_valid` stays 0 and `rd_data` keeps its previous value.
- R6: Writes offered with `ts_enable`=0 or `power_down`=1 change nothing: they count neither towards the prefill nor as data.
- R7: After an overflow or underflow restart, PREFILL new accepted writes are needed before `free_run` falls again.
- R8: `ovf_flag` and `unf_flag` are sticky and are cleared by a one-cycle pulse on `ovf_clr` / `unf_clr`. A new event in the same cycle as its clear leaves the flag set.
- R9: During and after reset, `free_run`=1, `rd_valid`=0, `rd_data`=0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_enable | input | 1 | Port uses timestamps |
| power_down | input | 1 | Port powered down |
| wr_valid | input | 1 | Timestamp value offered |
| wr_data | input | TS_W | Timestamp value |
| rd_req | input | 1 | PLL read tick |
| rd_data | output | TS_W | Last delivered timestamp |
| rd_valid | output | 1 | rd_data updated this cycle |
| free_run | output | 1 | PLL must free-run |
| ovf_flag | output | 1 | Sticky overflow indication |
| unf_flag | output | 1 | Sticky underflow indication |
| ovf_clr | input | 1 | Clear strobe for ovf_flag |
| unf_clr | input | 1 | Clear strobe for unf_flag |

## Verification
The hardest cases to reach from the ports are the two restart edges that coincide with an opposite-side transfer. One is an overflow where the PLL reads in the same cycle. The other is an underflow where a new value arrives in the same cycle. Both depend on the exact fill level, which is visible only through `free_run` and the delivered data. The stimulus first walks the buffer through prefill and a full drain to reach empty-while-running, then issues a read together with a write. It then refills to exactly DEPTH with writes only and offers one more write together with a read. A reference queue in the bench predicts every delivered value, and any discarded entry shows up as a data mismatch after the next prefill.

// File: rtl/ts_fifo_pkg.sv
package ts_fifo_pkg;
  typedef enum logic {ST_FILL, ST_RUN} fill_state_e;

  // occupancy after one cycle of push/pop
  function automatic int unsigned fill_next(int unsigned fill, logic push, logic pop);
    return fill + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // circular pointer advance for any depth
  function automatic int unsigned ptr_next(int unsigned ptr, int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/ts_store.sv
module ts_store #(
  parameter int TS_W  = 4,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [TS_W-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [TS_W-1:0] rdata
);
  logic [TS_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ts_ctrl.sv
module ts_ctrl
  import ts_fifo_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int PREFILL = 5,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic          rd_req,
  output logic          push,
  output logic          pop,
  output logic          overflow_ev,
  output logic          underflow_ev,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          running
);
  fill_state_e state, state_nxt;
  logic          restart;
  logic [CW-1:0] count_nxt;

  assign running      = (state == ST_RUN);
  assign underflow_ev = running && rd_req && (count == '0);
  assign overflow_ev  = wr_ok && (count == CW'(DEPTH)) && !underflow_ev;
  assign restart      = underflow_ev || overflow_ev;
  assign pop          = running && rd_req && (count != '0) && !restart;
  assign push         = wr_ok && !restart;

  always_comb begin
    count_nxt = restart ? '0 : CW'(fill_next(int'(count), push, pop));
    state_nxt = state;
    if (restart) state_nxt = ST_FILL;
    else if (state == ST_FILL && int'(count_nxt) >= PREFILL) state_nxt = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FILL;
      count <= '0;
      waddr <= '0;
      raddr <= '0;
    end else begin
      state <= state_nxt;
      count <= count_nxt;
      if (restart) begin
        waddr <= '0;
        raddr <= '0;
      end else begin
        if (push) waddr <= AW'(ptr_next(int'(waddr), DEPTH));
        if (pop)  raddr <= AW'(ptr_next(int'(raddr), DEPTH));
      end
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R6
  gated_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !pop && !underflow_ev) |=> (count == $past(count)));

  // R7
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> (running == (int'(count) >= PREFILL)));
endmodule

// File: rtl/ts_jitter_fifo.sv
module ts_jitter_fifo #(
  parameter int TS_W    = 4,
  parameter int DEPTH   = 8,
  parameter int PREFILL = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ts_enable,
  input  logic            power_down,
  input  logic            wr_valid,
  input  logic [TS_W-1:0] wr_data,
  input  logic            rd_req,
  output logic [TS_W-1:0] rd_data,
  output logic            rd_valid,
  output logic            free_run,
  output logic            ovf_flag,
  output logic            unf_flag,
  input  logic            ovf_clr,
  input  logic            unf_clr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic            wr_ok, push, pop, overflow_ev, underflow_ev, running;
  logic [AW-1:0]   waddr, raddr;
  logic [CW-1:0]   count;
  logic [TS_W-1:0] head;

  assign wr_ok    = wr_valid && ts_enable && !power_down;
  assign free_run = !running;

  ts_ctrl #(.DEPTH(DEPTH), .PREFILL(PREFILL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_req(rd_req),
    .push(push), .pop(pop), .overflow_ev(overflow_ev),
    .underflow_ev(underflow_ev), .waddr(waddr), .raddr(raddr),
    .count(count), .running(running)
  );

  ts_store #(.TS_W(TS_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(head)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      rd_valid <= pop;
      if (pop) rd_data <= head;
      ovf_flag <= overflow_ev  || (ovf_flag && !ovf_clr);
      unf_flag <= underflow_ev || (unf_flag && !unf_clr);
    end
  end

  // R2
  fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && rd_req) |=> !rd_valid);

  // R3
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rd_valid);

  // R4
  ovf_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_ev |=> (free_run && ovf_flag && count == '0));

  // R5
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_ev |=> (free_run && unf_flag && !rd_valid && $stable(rd_data)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: tb/ts_jitter_fifo_test.sv
module ts_jitter_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int PREFILL = 5;

  logic clk = 0, rst_n = 0;
  logic ts_enable = 1, power_down = 0, wr_valid = 0, rd_req = 0;
  logic ovf_clr = 0, unf_clr = 0;
  logic [3:0] wr_data = 0;
  logic [3:0] rd_data;
  logic rd_valid, free_run, ovf_flag, unf_flag;

  int total = 0, fails = 0, cyc = 0;
  logic [3:0] m_q[$];
  logic [3:0] exp_q[$];
  logic m_run = 0, m_ovf = 0, m_unf = 0, exp_valid = 0;
  logic [3:0] m_last = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_jitter_fifo #(.TS_W(4), .DEPTH(DEPTH), .PREFILL(PREFILL)) uut (
    .clk(clk), .rst_n(rst_n), .ts_enable(ts_enable), .power_down(power_down),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .free_run(free_run),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor: compares delivered values against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 rd_valid", int'(rd_valid), int'(exp_valid));
      if (rd_valid && exp_q.size() > 0) chk("R1 R3 order", int'(rd_data), int'(exp_q.pop_front()));
    end
  end

  // driver: one cycle, updates the reference model, checks status outputs
  task automatic step(input string tag, input logic wv, input logic [3:0] wd,
                      input logic rr, input logic oc = 0, input logic uc = 0);
    logic wr_ok, ov, un;
    logic [3:0] v;
    wr_valid = wv; wr_data = wd; rd_req = rr; ovf_clr = oc; unf_clr = uc;
    @(posedge clk);
    wr_ok = wv && ts_enable && !power_down;
    ov = 0; un = 0; exp_valid = 0;
    if (m_run && rr && m_q.size() == 0) begin
      m_q.delete(); m_run = 0; un = 1;
    end else if (wr_ok && m_q.size() == DEPTH) begin
      m_q.delete(); m_run = 0; ov = 1;
    end else begin
      if (m_run && rr) begin
        v = m_q.pop_front(); exp_q.push_back(v); m_last = v; exp_valid = 1;
      end
      if (wr_ok) m_q.push_back(wd);
      if (!m_run && m_q.size() >= PREFILL) m_run = 1;
    end
    m_ovf = ov || (m_ovf && !oc);
    m_unf = un || (m_unf && !uc);
    @(negedge clk);
    chk({tag, " free_run"}, int'(free_run), int'(!m_run));
    chk({tag, " ovf_flag"}, int'(ovf_flag), int'(m_ovf));
    chk({tag, " unf_flag"}, int'(unf_flag), int'(m_unf));
    chk({tag, " rd_data"},  int'(rd_data),  int'(m_last));
    wr_valid = 0; rd_req = 0; ovf_clr = 0; unf_clr = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; total++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 free_run", int'(free_run), 1);
    chk("R9 rd_valid", int'(rd_valid), 0);
    chk("R9 rd_data", int'(rd_data), 0);
    chk("R9 flags", int'({ovf_flag, unf_flag}), 0);
    rst_n = 1;
    // R2: reads ignored during prefill
    for (int i = 0; i < 3; i++) step("R2", 1, 4'(i + 1), 1);
    step("R2", 1, 4'h4, 0);
    // R6: gated writes do not count
    ts_enable = 0; step("R6 disabled", 1, 4'hE, 0);
    ts_enable = 1; power_down = 1; step("R6 powerdown", 1, 4'hD, 1);
    power_down = 0;
    step("R2 fifth", 1, 4'h5, 0);
    // R3: steady reads with interleaved writes
    step("R3", 1, 4'h6, 1);
    step("R3", 0, 0, 1);
    step("R3", 1, 4'h7, 1);
    for (int i = 0; i < 4; i++) step("R3 drain", 0, 0, 1);
    // R5: underflow with simultaneous write
    step("R5 underflow", 1, 4'h9, 1);
    step("R5 hold", 0, 0, 1);
    // R7: refill after restart
    for (int i = 0; i < 4; i++) step("R7", 1, 4'(8 + i), 1);
    step("R7 fifth", 1, 4'hC, 0);
    for (int i = 0; i < 3; i++) step("R4 fill", 1, 4'(i), 0);
    // R4: overflow with simultaneous read
    step("R4 overflow", 1, 4'hF, 1);
    // R8: clear and set-over-clear
    step("R8 clear", 0, 0, 0, 1, 1);
    for (int i = 0; i < PREFILL; i++) step("R7 refill", 1, 4'(3 + i), 0);
    for (int i = 0; i < PREFILL; i++) step("R1 drain", 0, 0, 1);
    step("R8 unf", 0, 0, 1);
    step("R8 set-over-clear", 0, 0, 0, 0, 1);
    for (int i = 0; i < PREFILL; i++) step("R8 refill", 1, 4'(i), 0);
    for (int i = 0; i < PREFILL; i++) step("R8 drain", 0, 0, 1);
    step("R8 simultaneous", 0, 0, 1, 0, 1);
    step("R8 idle", 0, 0, 0);
    summary();
  end
endmodule